// File: doc/BRIEF.md
# TDM Transmit Frame Buffer

This block sits between a host write port and the transmit side of a serial time-slot interface. The host loads one frame's worth of bytes into a 32-entry, 8-bit store. The serial side then takes them back one byte per handled slot, in the order they were written. The number of handled slots comes from two configuration inputs. One gives the index of the last handled slot, and the other gives the count of slots dropped ahead of the first handled one.

Transmission works a whole frame at a time. At a frame start, the buffered bytes are sent only if the full handled count is present. Otherwise the frame is aborted: an underflow flag is raised and every byte requested during that frame reads as all ones. The block keeps an empty/done flag and raises a one-cycle interrupt when that flag comes up. It also keeps sticky overflow and underflow flags, which a status read clears. The storage has one port. Reads for the serial side and host writes share it, and a read always takes the port.

Top module: `tdm_tx_buf`

## Requirements
- R1: Storage holds DEPTH (default 32) bytes. Bytes are handed to the serial side in the order the host wrote them. The storage has a single port, which a serial read takes ahead of a host write.
- R2: While reset is asserted, `status_o` is 0x00, `done_irq_o` is 0 and `tx_byte_o` is 0xFF. On the first clock edge after reset, the done flag (status bit 0) sets and `done_irq_o` pulses. A host write made while the done flag is still 0 and no byte is buffered is ignored.
- R3: The handled count is `cfg_last_i - cfg_drop_i + 1` when `cfg_last_i >= cfg_drop_i`, and 1 otherwise.
- R4: A host write is accepted only when fewer bytes than the handled count are buffered. A write made when that count is already reached is ignored and sets the overflow flag (status bit 1).
- R5: The first accepted write of a frame clears the done flag at that clock edge.
- R6: A `frame_start_i` pulse with exactly the handled count buffered starts transmission. Each `byte_req_i` then presents the next byte on `tx_byte_o` one cycle later. A `byte_req_i` in the same cycle as `frame_start_i` counts as the first request.
- R7: When the last byte of a sending frame is requested, the buffer empties, the done flag sets again and `done_irq_o` pulses for exactly one cycle.
- R8: A `frame_start_i` pulse with fewer bytes than the handled count sets the underflow flag (status bit 2). The bytes already buffered are kept and can still be completed.
- R9: A `byte_req_i` that does not belong to a sending frame presents 0xFF on `tx_byte_o` one cycle later.
- R10: The overflow and underflow flags are sticky and clear on `stat_rd_i`. If a set and a clear happen in the same cycle, the set wins.
- R11: Status bit 3 is written from `ctl_bit_i` when `ctl_wr_i` is high. Status bits 7..4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_last_i | input | 5 | Index of the last handled slot |
| cfg_drop_i | input | 5 | Number of slots skipped before the first handled slot |
| host_wr_i | input | 1 | Host byte write strobe |
| host_data_i | input | 8 | Host write data |
| stat_rd_i | input | 1 | Status read; clears the sticky flags |
| ctl_wr_i | input | 1 | Write strobe for status bit 3 |
| ctl_bit_i | input | 1 | Value written to status bit 3 |
| frame_start_i | input | 1 | Pulse at the first handled slot of a frame |
| byte_req_i | input | 1 | Serial side requests the next byte |
| tx_byte_o | output | 8 | Byte for the serial side |
| status_o | output | 8 | {0000, ctl, underflow, overflow, done} |
| done_irq_o | output | 1 | One-cycle pulse when the done flag rises |

## Verification
The bench builds the block with its default parameters: 32 entries of 8 bits and 5-bit slot fields. These defaults let a complete 32-byte frame (last slot 31, no drops) fill the store, overflow it and drain it end to end. The same build also reaches the clamped single-slot case where the drop count exceeds the last-slot index. Aborted frames are driven against partly filled and empty buffers, and the sticky flags are cleared both on their own and in a cycle where a new flag event occurs.

// File: rtl/tdm_txb_pkg.sv
package tdm_txb_pkg;
  localparam int unsigned TXB_DEPTH  = 32;
  localparam int unsigned TXB_DATA_W = 8;

  typedef struct packed {
    logic [3:0] zero;
    logic       ctl;
    logic       unf;
    logic       ovf;
    logic       done;
  } txb_status_t;
endpackage

// File: rtl/tdm_txb_cfg.sv
module tdm_txb_cfg #(
  parameter int unsigned SLOT_W = 5,
  localparam int unsigned CNT_W = SLOT_W + 1
) (
  input  logic [SLOT_W-1:0] last_i,
  input  logic [SLOT_W-1:0] drop_i,
  output logic [CNT_W-1:0]  handled_o
);
  always_comb begin
    if (last_i >= drop_i) handled_o = {1'b0, last_i - drop_i} + CNT_W'(1);
    else                  handled_o = CNT_W'(1);
  end
endmodule

// File: rtl/tdm_txb_mem.sv
module tdm_txb_mem #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/tdm_txb_ctrl.sv
module tdm_txb_ctrl #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  handled_i,
  input  logic              host_wr_i,
  input  logic              frame_start_i,
  input  logic              byte_req_i,
  input  logic              stat_rd_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [CNT_W-1:0] wr_cnt_q, rd_ptr_q, rd_base;
  logic sending_q, done_q, irq_q, ovf_q, unf_q;
  logic full, start_ok, start_bad, eff_send, rd_en, last_rd;
  logic wr_open, wr_ok, wr_ovf, done_d;

  assign full      = (wr_cnt_q == handled_i);
  assign start_ok  = frame_start_i && !sending_q && full;
  assign start_bad = frame_start_i && !sending_q && !full;
  assign eff_send  = sending_q || start_ok;
  assign rd_base   = start_ok ? '0 : rd_ptr_q;
  assign rd_en     = byte_req_i && eff_send;
  assign last_rd   = rd_en && (rd_base == handled_i - CNT_W'(1));

  // host may write once done is seen or while a frame is partly loaded
  assign wr_open = done_q || (wr_cnt_q != '0);
  assign wr_ok   = host_wr_i && wr_open && (wr_cnt_q < handled_i) && !eff_send;
  assign wr_ovf  = host_wr_i && wr_open && (wr_cnt_q >= handled_i);

  always_comb begin
    if (wr_ok)                done_d = 1'b0;
    else if (last_rd)         done_d = 1'b1;
    else if (wr_cnt_q == '0)  done_d = 1'b1;
    else                      done_d = done_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q  <= '0;
      rd_ptr_q  <= '0;
      sending_q <= 1'b0;
      done_q    <= 1'b0;
      irq_q     <= 1'b0;
      ovf_q     <= 1'b0;
      unf_q     <= 1'b0;
    end else begin
      if (last_rd)    wr_cnt_q <= '0;
      else if (wr_ok) wr_cnt_q <= wr_cnt_q + CNT_W'(1);
      rd_ptr_q  <= rd_base + CNT_W'(rd_en);
      if (last_rd)       sending_q <= 1'b0;
      else if (start_ok) sending_q <= 1'b1;
      done_q <= done_d;
      irq_q  <= done_d && !done_q;
      if (wr_ovf)         ovf_q <= 1'b1;
      else if (stat_rd_i) ovf_q <= 1'b0;
      if (start_bad)      unf_q <= 1'b1;
      else if (stat_rd_i) unf_q <= 1'b0;
    end
  end

  // read owns the single port; a write never coincides with a sending frame
  assign mem_we_o   = wr_ok;
  assign mem_re_o   = rd_en;
  assign mem_addr_o = rd_en ? rd_base[ADDR_W-1:0] : wr_cnt_q[ADDR_W-1:0];
  assign done_o     = done_q;
  assign irq_o      = irq_q;
  assign ovf_o      = ovf_q;
  assign unf_o      = unf_q;
endmodule

// File: rtl/tdm_tx_buf.sv
module tdm_tx_buf
  import tdm_txb_pkg::*;
#(
  parameter int unsigned DEPTH  = TXB_DEPTH,
  parameter int unsigned DATA_W = TXB_DATA_W,
  localparam int unsigned SLOT_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = SLOT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SLOT_W-1:0] cfg_last_i,
  input  logic [SLOT_W-1:0] cfg_drop_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              stat_rd_i,
  input  logic              ctl_wr_i,
  input  logic              ctl_bit_i,
  input  logic              frame_start_i,
  input  logic              byte_req_i,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic [7:0]        status_o,
  output logic              done_irq_o
);
  logic [CNT_W-1:0]  handled;
  logic              mem_we, mem_re, done, ovf, unf;
  logic [SLOT_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic              sel_mem_q, ctl_q;
  txb_status_t       stat;

  tdm_txb_cfg #(.SLOT_W(SLOT_W)) u_cfg (
    .last_i(cfg_last_i), .drop_i(cfg_drop_i), .handled_o(handled)
  );

  tdm_txb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni,
    .handled_i(handled), .host_wr_i, .frame_start_i, .byte_req_i, .stat_rd_i,
    .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .done_o(done), .irq_o(done_irq_o), .ovf_o(ovf), .unf_o(unf)
  );

  tdm_txb_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
    .clk_i, .we_i(mem_we), .re_i(mem_re), .addr_i(mem_addr),
    .wdata_i(host_data_i), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_mem_q <= 1'b0;
      ctl_q     <= 1'b0;
    end else begin
      if (byte_req_i) sel_mem_q <= mem_re;
      if (ctl_wr_i)   ctl_q     <= ctl_bit_i;
    end
  end

  assign tx_byte_o = sel_mem_q ? mem_rdata : {DATA_W{1'b1}};

  always_comb begin
    stat.zero = '0;
    stat.ctl  = ctl_q;
    stat.unf  = unf;
    stat.ovf  = ovf;
    stat.done = done;
  end
  assign status_o = stat;
endmodule

// File: rtl/tdm_tx_buf_chk.sv
module tdm_tx_buf_chk #(
  parameter int unsigned SLOT_W = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SLOT_W-1:0] cfg_last_i,
  input logic [SLOT_W-1:0] cfg_drop_i,
  input logic              host_wr_i,
  input logic [DATA_W-1:0] host_data_i,
  input logic              stat_rd_i,
  input logic              ctl_wr_i,
  input logic              ctl_bit_i,
  input logic              frame_start_i,
  input logic              byte_req_i,
  input logic [DATA_W-1:0] tx_byte_o,
  input logic [7:0]        status_o,
  input logic              done_irq_o
);
  AST_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:4] == 4'h0); // R11

  AST_CTL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_i |=> status_o[3] == $past(ctl_bit_i)); // R11

  AST_IRQ_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> status_o[0] && !$past(status_o[0])); // R7

  AST_DONE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && status_o[0] |=> !status_o[0]); // R5

  AST_EMPTY_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && status_o[0] |=> status_o[2]); // R8

  AST_ABORT_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i && byte_req_i && status_o[0] |=> tx_byte_o == {DATA_W{1'b1}}); // R9

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] && !stat_rd_i |=> status_o[1]); // R10

  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] && !stat_rd_i |=> status_o[2]); // R10

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_req_i && !$past(byte_req_i) && !host_wr_i && !$past(host_wr_i)
      && $stable(cfg_last_i) && $stable(cfg_drop_i) && $past(host_data_i) == host_data_i
      |=> $stable(tx_byte_o)); // R6
endmodule

bind tdm_tx_buf tdm_tx_buf_chk #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tdm_tx_buf_tb_top.sv
module tdm_tx_buf_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] cfg_last_i = '0, cfg_drop_i = '0;
  logic       host_wr_i = 0, stat_rd_i = 0, ctl_wr_i = 0, ctl_bit_i = 0;
  logic       frame_start_i = 0, byte_req_i = 0;
  logic [7:0] host_data_i = '0;
  logic [7:0] tx_byte_o, status_o;
  logic       done_irq_o;

  int n_chk = 0, n_err = 0;
  bit done_run = 0;

  always #2 clk_i = ~clk_i;

  tdm_tx_buf dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic host_write(input logic [7:0] d);
    host_wr_i = 1; host_data_i = d; step(); host_wr_i = 0;
  endtask

  task automatic clear_stat();
    stat_rd_i = 1; step(); stat_rd_i = 0;
  endtask

  // sends n bytes with frame_start on the first request; expects data[i]
  task automatic send_frame(input int n, input logic [7:0] base, input int mul, input string req);
    for (int i = 0; i < n; i++) begin
      frame_start_i = (i == 0); byte_req_i = 1; step();
      chk(tx_byte_o == 8'(base + i*mul), req, tx_byte_o, 8'(base + i*mul));
      if (i == n-1) begin
        chk(status_o[0] == 1'b1, "R7", status_o[0], 1);
        chk(done_irq_o == 1'b1, "R7", done_irq_o, 1);
      end else
        chk(status_o[0] == 1'b0, req, status_o[0], 0);
    end
    frame_start_i = 0; byte_req_i = 0; step();
    chk(done_irq_o == 1'b0, "R7", done_irq_o, 0);
  endtask

  task automatic t_reset();
    #3;
    chk(status_o == 8'h00, "R2", status_o, 0);
    chk(done_irq_o == 1'b0, "R2", done_irq_o, 0);
    chk(tx_byte_o == 8'hFF, "R2", tx_byte_o, 8'hFF);
    host_wr_i = 1; host_data_i = 8'h55;
    @(negedge clk_i); rst_ni = 1;
    step(); host_wr_i = 0;
    chk(status_o == 8'h01, "R2", status_o, 1);
    chk(done_irq_o == 1'b1, "R2", done_irq_o, 1);
    step();
    chk(status_o[0] == 1'b1, "R2 ignored write", status_o[0], 1);
    chk(done_irq_o == 1'b0, "R2", done_irq_o, 0);
  endtask

  task automatic t_basic();
    cfg_last_i = 5'd3; cfg_drop_i = 5'd1;  // R3: three slots
    host_write(8'h11);
    chk(status_o[0] == 1'b0, "R5", status_o[0], 0);
    host_write(8'h22); host_write(8'h33);
    chk(status_o == 8'h00, "R4", status_o, 0);
    host_write(8'h44);
    chk(status_o == 8'h02, "R4 overflow", status_o, 2);
    step();
    chk(status_o[1] == 1'b1, "R10 sticky", status_o[1], 1);
    clear_stat();
    chk(status_o[1] == 1'b0, "R10 clear", status_o[1], 0);
    send_frame(3, 8'h11, 8'h11, "R6");
    byte_req_i = 1; step(); byte_req_i = 0;
    chk(tx_byte_o == 8'hFF, "R9", tx_byte_o, 8'hFF);
  endtask

  task automatic t_underflow();
    cfg_last_i = 5'd2; cfg_drop_i = 5'd0;  // R3: three slots
    host_write(8'hA0); host_write(8'hA1);
    frame_start_i = 1; byte_req_i = 1; step(); frame_start_i = 0;
    chk(status_o[2] == 1'b1, "R8", status_o[2], 1);
    chk(tx_byte_o == 8'hFF, "R8 ones", tx_byte_o, 8'hFF);
    step(); byte_req_i = 0;
    chk(tx_byte_o == 8'hFF, "R9", tx_byte_o, 8'hFF);
    host_write(8'hA2);
    clear_stat();
    chk(status_o == 8'h00, "R10", status_o, 0);
    send_frame(3, 8'hA0, 1, "R8 retained");
    frame_start_i = 1; step(); frame_start_i = 0;
    chk(status_o[2] == 1'b1, "R8 empty", status_o[2], 1);
    clear_stat();
  endtask

  task automatic t_full();
    cfg_last_i = 5'd31; cfg_drop_i = 5'd0;  // R3: 32 slots
    for (int i = 0; i < 32; i++) host_write(8'(i*7 + 1));
    chk(status_o == 8'h00, "R1", status_o, 0);
    // overflow in the same cycle as a status read: set wins
    host_wr_i = 1; host_data_i = 8'hEE; stat_rd_i = 1; step();
    host_wr_i = 0; stat_rd_i = 0;
    chk(status_o[1] == 1'b1, "R10 set wins", status_o[1], 1);
    clear_stat();
    send_frame(32, 8'h01, 7, "R1");
  endtask

  task automatic t_clamp();
    cfg_last_i = 5'd2; cfg_drop_i = 5'd5;  // R3: clamps to one slot
    host_write(8'h5A);
    host_write(8'h5B);
    chk(status_o[1] == 1'b1, "R3 clamp", status_o[1], 1);
    clear_stat();
    send_frame(1, 8'h5A, 0, "R3");
  endtask

  task automatic t_ctl();
    ctl_wr_i = 1; ctl_bit_i = 1; step(); ctl_wr_i = 0;
    chk(status_o == 8'h09, "R11", status_o, 8'h09);
    ctl_wr_i = 1; ctl_bit_i = 0; step(); ctl_wr_i = 0;
    chk(status_o == 8'h01, "R11", status_o, 8'h01);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_underflow();
    t_full();
    t_clamp();
    t_ctl();
    done_run = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done_run; c++) @(posedge clk_i);
    if (!done_run) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule